// File: doc/BRIEF.md
# Lookahead-Driven Multithread Issue Tracker

This block sits at the front of a deep, non-bypassed pipeline that is shared by many hardware threads. Each cycle it picks at most one thread to launch an instruction. For every thread it tracks two things: how many more independent instructions that thread may still send, and how long the thread must wait for its latest results. No hazard detection is done here. The only dependency information is the lookahead count (0 to 7) carried by each instruction. This count says how many of the thread's next instructions do not depend on it. The tracker combines it with the pipeline latency (21 cycles) or the memory latency (150 cycles) to decide when the thread may issue again.

The surrounding fetch logic reads `issue_valid` and `issue_tid` in a cycle. In that same cycle it returns the lookahead field and the memory-operation flag of the instruction it launches for that thread. Threads are switched on and off with one-cycle pulses on the per-thread activate and terminate inputs. When several threads are ready, a rotating round-robin arbiter chooses among them. When none is ready, the tracker emits a bubble.

Top module: `mt_issue_tracker`

## Requirements
- R1: After reset no thread is active. `issue_valid` stays 0 until a thread is activated, including the first cycle after reset.
- R2: At most one thread is granted per cycle. A grant only goes to a thread that is active and eligible. A thread is eligible when it has remaining lookahead credit or its stall timer has run out.
- R3: A thread activated by a pulse in cycle t can be granted in cycle t+1. Activating a thread that is already active has no effect.
- R4: A thread whose terminate input is high in cycle t can still be granted in cycle t. It is never granted from cycle t+1 on until it is activated again. If terminate and activate are both high for the same thread in the same cycle, terminate wins.
- R5: A window head is an instruction issued when the thread has no lookahead credit left. If the head is not a memory operation and has lookahead 0, the same thread issues again no earlier than 21 cycles later. If that thread is the only one active, it issues again exactly 21 cycles later.
- R6: A window head that is a memory operation with lookahead 0 blocks its thread for 150 cycles. When the thread is alone, its next issue comes exactly 150 cycles later.
- R7: A window head with lookahead L gives its thread L further issues with no waiting. The lookahead fields of those L instructions are ignored. The instruction after them waits until the latency of the head, and the latency of every instruction in the window, has passed from that instruction's own issue cycle.
- R8: The grant goes to the first eligible thread after the most recently granted one, wrapping from the highest index to 0. After reset, thread 0 has the highest priority.
- R9: When no thread is eligible, `issue_valid` is 0 and `issue_tid` is 0.
- R10: `issue_lookahead` and `issue_is_mem` are only sampled in a cycle with `issue_valid` = 1. In any other cycle they have no effect.
- R11: A thread that is terminated and then activated again starts fresh. Any credit or stall timer it had before is discarded, so it can be granted in the cycle after the new activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| thr_activate | input | NUM_THREADS | One-cycle pulse per thread that sets its active flag |
| thr_terminate | input | NUM_THREADS | One-cycle pulse per thread that clears its active flag and its state |
| issue_lookahead | input | 3 | Lookahead count of the instruction launched this cycle |
| issue_is_mem | input | 1 | 1 when the instruction launched this cycle is a memory operation |
| issue_valid | output | 1 | A thread is granted this cycle |
| issue_tid | output | clog2(NUM_THREADS) | Granted thread number, 0 on a bubble |

## Verification
The hardest case to reach from the ports is a window that ends while its head's latency is still running. In that case the wait after the last window member must be the longer of the remaining head latency and the member's own latency. The bench gets there by giving a memory-operation head a lookahead of 2 and sending two plain members right behind it. The gap before the next issue must then be 148 cycles, not 21. A second hard case is a thread that is terminated while it is stalled and then reactivated. Here the bench sets up a 150-cycle stall first, then pulses terminate and activate, and expects an issue in the very next cycle.

// File: rtl/mt_issue_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the multithread issue tracker.
// Assumes: the lookahead field width is fixed by the instruction encoding.
package mt_issue_pkg;
    localparam int LA_W = 3;          // lookahead field width (values 0..7)
    typedef logic [LA_W-1:0] la_t;    // lookahead count of one instruction

    // Larger of two latencies; used to size the stall timers.
    function automatic int lat_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/mt_thread_ctx.sv
`timescale 1ns/1ps
// Module: per-thread issue context.
// Holds the active flag, the remaining independent-issue credit and a stall
// timer for one hardware thread, and reports whether the thread may issue.
// Assumes: 'issued' is only raised while the thread is active and eligible;
// terminate takes priority over activate; latencies are at least 1.
module mt_thread_ctx
    import mt_issue_pkg::*;
#(
    parameter int PIPE_LAT = 21,
    parameter int MEM_LAT  = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activate,
    input  logic terminate,
    input  logic issued,
    input  la_t  lookahead,
    input  logic is_mem,
    output logic active,
    output logic eligible
);
    localparam int MAX_LAT = lat_max(PIPE_LAT, MEM_LAT);
    localparam int WAIT_W  = $clog2(MAX_LAT + 1);

    logic              act_q;
    la_t               credit_q;
    logic [WAIT_W-1:0] wait_q;
    logic [WAIT_W-1:0] wait_dec;
    logic [WAIT_W-1:0] lat_m1;
    logic [WAIT_W-1:0] wait_merge;

    // Latency of the instruction launched now, minus the issue cycle itself.
    always_comb begin
        lat_m1 = is_mem ? WAIT_W'(MEM_LAT - 1) : WAIT_W'(PIPE_LAT - 1);
    end

    // Timer value one cycle on, saturating at zero.
    always_comb begin
        wait_dec = (wait_q == '0) ? '0 : wait_q - 1'b1;
    end

    // Inside a window, keep the longest outstanding latency.
    always_comb begin
        wait_merge = (wait_dec > lat_m1) ? wait_dec : lat_m1;
    end

    // Eligible when credit remains or all prior latencies have elapsed.
    always_comb begin
        eligible = act_q && ((credit_q != '0) || (wait_q == '0));
        active   = act_q;
    end

    // Thread state update: terminate, activate, issue bookkeeping, timer tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            credit_q <= '0;
            wait_q   <= '0;
        end else if (terminate) begin
            act_q    <= 1'b0;
            credit_q <= '0;
            wait_q   <= '0;
        end else if (activate && !act_q) begin
            act_q    <= 1'b1;
            credit_q <= '0;
            wait_q   <= '0;
        end else if (issued) begin
            if (credit_q != '0) begin
                credit_q <= credit_q - 1'b1;
                wait_q   <= wait_merge;
            end else begin
                credit_q <= lookahead;
                wait_q   <= lat_m1;
            end
        end else begin
            wait_q <= wait_dec;
        end
    end
endmodule

// File: rtl/mt_rr_arbiter.sv
`timescale 1ns/1ps
// Module: rotating-priority round-robin arbiter.
// Grants the first requester after the last granted index, wrapping around.
// Assumes: N >= 2; the pointer resets to N-1 so index 0 is first in line.
module mt_rr_arbiter #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx,
    output logic [N-1:0]     gnt_oh
);
    logic [IDX_W-1:0] last_q;

    // Scan requesters starting one past the last grant.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        gnt_oh    = '0;
        for (int k = 1; k <= N; k++) begin
            int cand;
            cand = (int'(last_q) + k) % N;
            if (!gnt_valid && req[cand]) begin
                gnt_valid    = 1'b1;
                gnt_idx      = IDX_W'(cand);
                gnt_oh[cand] = 1'b1;
            end
        end
    end

    // Remember the most recent grant for the next rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDX_W'(N - 1);
        end else if (gnt_valid) begin
            last_q <= gnt_idx;
        end
    end
endmodule

// File: rtl/mt_issue_tracker.sv
`timescale 1ns/1ps
// Module: lookahead-driven multithread issue tracker (top).
// Each cycle it grants at most one eligible thread. The instruction then
// launched reports its lookahead count and memory flag in the same cycle,
// and those values update the granted thread's credit and stall timer.
// Assumes: fetch returns lookahead/is_mem combinationally for the grant.
module mt_issue_tracker
    import mt_issue_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int PIPE_LAT    = 21,
    parameter int MEM_LAT     = 150,
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] thr_activate,
    input  logic [NUM_THREADS-1:0] thr_terminate,
    input  logic [LA_W-1:0]        issue_lookahead,
    input  logic                   issue_is_mem,
    output logic                   issue_valid,
    output logic [TID_W-1:0]       issue_tid
);
    logic [NUM_THREADS-1:0] act_vec;
    logic [NUM_THREADS-1:0] elig_vec;
    logic [NUM_THREADS-1:0] gnt_oh;
    logic                   gnt_valid;
    logic [TID_W-1:0]       gnt_idx;

    // One context per hardware thread.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        mt_thread_ctx #(
            .PIPE_LAT (PIPE_LAT),
            .MEM_LAT  (MEM_LAT)
        ) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .activate  (thr_activate[t]),
            .terminate (thr_terminate[t]),
            .issued    (gnt_oh[t]),
            .lookahead (issue_lookahead),
            .is_mem    (issue_is_mem),
            .active    (act_vec[t]),
            .eligible  (elig_vec[t])
        );
    end

    mt_rr_arbiter #(
        .N (NUM_THREADS)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (elig_vec),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .gnt_oh    (gnt_oh)
    );

    // Drive the issue port from the arbiter result.
    always_comb begin
        issue_valid = gnt_valid;
        issue_tid   = gnt_idx;
    end
endmodule

// File: rtl/mt_issue_tracker_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to the issue tracker top.
// Assumes: bound inside mt_issue_tracker so internal vectors are visible.
module mt_issue_tracker_chk #(
    parameter int N     = 8,
    parameter int TID_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic [TID_W-1:0] issue_tid,
    input logic [N-1:0]     thr_terminate,
    input logic [N-1:0]     act_vec,
    input logic [N-1:0]     gnt_oh
);
    logic         seen_q;
    logic [N-1:0] term_d;

    // Track first cycle out of reset and last cycle's terminate pulses.
    always_ff @(posedge clk) begin
        seen_q <= rst_n;
        term_d <= rst_n ? thr_terminate : '0;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !issue_valid);

    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh));

    p_grant_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (int'(issue_tid) < N) && act_vec[issue_tid]);

    p_no_grant_after_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && issue_valid) |-> !term_d[issue_tid]);

    p_bubble_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (issue_tid == '0) && (gnt_oh == '0));
endmodule

bind mt_issue_tracker mt_issue_tracker_chk #(
    .N     (NUM_THREADS),
    .TID_W (TID_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid   (issue_valid),
    .issue_tid     (issue_tid),
    .thr_terminate (thr_terminate),
    .act_vec       (act_vec),
    .gnt_oh        (gnt_oh)
);

// File: tb/mt_issue_tracker_bench.sv
`timescale 1ns/1ps
// Directed bench for mt_issue_tracker: one task per scenario.
// Inputs change and outputs are sampled at the falling edge.
module mt_issue_tracker_bench;
    localparam int N  = 8;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  act = '0;
    logic [N-1:0]  term = '0;
    logic [2:0]    la = '0;
    logic          mem = 1'b0;
    logic          iv;
    logic [TW-1:0] tid;

    int n_chk = 0;
    int n_bad = 0;
    int bub_err = 0;

    always #10 clk = ~clk;

    mt_issue_tracker u_mt_issue_tracker (
        .clk             (clk),
        .rst_n           (rst_n),
        .thr_activate    (act),
        .thr_terminate   (term),
        .issue_lookahead (la),
        .issue_is_mem    (mem),
        .issue_valid     (iv),
        .issue_tid       (tid)
    );

    task automatic chk(input bit ok, input string req, input int a, input int e);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, a, e);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; act = '0; term = '0; la = '0; mem = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic pulse_act(input logic [N-1:0] m);
        act = m;
        tick();
        act = '0;
    endtask

    // Advance to the next issue; la/mem are cleared after the current cycle.
    task automatic next_issue(output int gap, output int t);
        gap = 0;
        do begin
            tick();
            gap++;
            if (gap == 1) begin la = '0; mem = 1'b0; end
            if (!iv && tid != '0) bub_err++;
        end while (!iv && gap < 400);
        t = iv ? int'(tid) : -1;
    endtask

    task automatic t_reset();
        do_reset();
        chk(!iv, "R1 idle right after reset", int'(iv), 0);
        tick();
        chk(!iv && tid == '0, "R1/R9 no grant without activation", int'(iv), 0);
    endtask

    task automatic t_plain();
        int g, t;
        do_reset();
        pulse_act(8'b0000_1000);
        chk(iv && tid == 3'd3, "R3 granted cycle after activation", int'(tid), 3);
        next_issue(g, t);
        chk(g == 21 && t == 3, "R5 plain lookahead-0 spacing", g, 21);
        pulse_act(8'b0000_1000);
        chk(!iv, "R3 re-activating active thread has no effect", int'(iv), 0);
    endtask

    task automatic t_mem();
        int g, t;
        do_reset();
        pulse_act(8'b0000_0001);
        mem = 1'b1;
        next_issue(g, t);
        chk(g == 150 && t == 0, "R6 memory lookahead-0 spacing", g, 150);
    endtask

    task automatic t_window();
        int g, t;
        do_reset();
        pulse_act(8'b0010_0000);
        la = 3'd3;
        for (int i = 0; i < 3; i++) begin
            if (i == 1) la = 3'd7;   // member lookahead must be ignored (R7)
            next_issue(g, t);
            if (i == 0) la = 3'd7;
            chk(g == 1 && t == 5, "R7 back-to-back window issue", g, 1);
        end
        la = '0;
        next_issue(g, t);
        chk(g == 21 && t == 5, "R7 wait after window", g, 21);
        la = 3'd2; mem = 1'b1;
        next_issue(g, t);
        chk(g == 1, "R7 memory head window issue 1", g, 1);
        next_issue(g, t);
        chk(g == 1, "R7 memory head window issue 2", g, 1);
        next_issue(g, t);
        chk(g == 148 && t == 5, "R7 head latency still pending", g, 148);
    endtask

    task automatic t_rr();
        int g, t;
        do_reset();
        bub_err = 0;
        pulse_act(8'b0101_0010);
        chk(iv && tid == 3'd1, "R8 first after reset pointer", int'(tid), 1);
        next_issue(g, t);
        chk(t == 4 && g == 1, "R8 rotation to 4", t, 4);
        next_issue(g, t);
        chk(t == 6 && g == 1, "R8 rotation to 6", t, 6);
        next_issue(g, t);
        chk(t == 1 && g == 19, "R8 wrap to 1 after stall", g, 19);
        chk(bub_err == 0, "R9 bubble tid is 0", bub_err, 0);
        do_reset();
        pulse_act(8'b0000_0011);
        la = 3'd7;
        chk(iv && tid == 3'd0, "R8 thread 0 first", int'(tid), 0);
        next_issue(g, t);
        la = 3'd7;
        chk(t == 1, "R8 alternate to 1", t, 1);
        for (int i = 0; i < 6; i++) begin
            next_issue(g, t);
            chk(g == 1 && t == (i % 2), "R8 alternation under contention", t, i % 2);
        end
    endtask

    task automatic t_term();
        int g, t, hits;
        do_reset();
        pulse_act(8'b0000_0100);
        la = 3'd7;
        next_issue(g, t);
        term = 8'b0000_0100;
        chk(iv && tid == 3'd2, "R4 still granted in terminate cycle", int'(tid), 2);
        tick();
        term = '0;
        la = '0;
        hits = 0;
        for (int i = 0; i < 30; i++) begin
            if (iv) hits++;
            tick();
        end
        chk(hits == 0, "R4 no grant after terminate", hits, 0);
        act = 8'b0010_0000; term = 8'b0010_0000;
        tick();
        act = '0; term = '0;
        hits = 0;
        for (int i = 0; i < 5; i++) begin
            if (iv) hits++;
            tick();
        end
        chk(hits == 0, "R4 terminate wins over activate", hits, 0);
        pulse_act(8'b0000_1000);
        mem = 1'b1;
        repeat (10) begin tick(); mem = 1'b0; end
        chk(!iv, "R11 thread stalled before terminate", int'(iv), 0);
        term = 8'b0000_1000;
        tick();
        term = '0;
        pulse_act(8'b0000_1000);
        chk(iv && tid == 3'd3, "R11 fresh after reactivation", int'(iv), 1);
    endtask

    task automatic t_ignore();
        int g, t;
        do_reset();
        la = 3'd7; mem = 1'b1;
        repeat (5) tick();
        la = '0; mem = 1'b0;
        pulse_act(8'b0000_0001);
        g = 0;
        do begin
            tick();
            g++;
            if (g < 15) begin la = 3'd7; mem = 1'b1; end
            else begin la = '0; mem = 1'b0; end
        end while (!iv && g < 300);
        chk(g == 21, "R10 stall unaffected by idle inputs", g, 21);
        next_issue(g, t);
        chk(g == 21 && t == 0, "R10 no credit from idle inputs", g, 21);
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_plain();
        t_mem();
        t_window();
        t_rr();
        t_term();
        t_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule